// File: doc/BRIEF.md
# Low-Power Edge Interrupt Recorder

This block sits between a bank of external interrupt lines and a main interrupt controller that may be switched off to save power. Software configures each line before the controller powers down. Each line has a mask bit, an edge or level sensitivity bit and a polarity bit. Software then arms the block. While the block is armed, every qualifying edge on an unmasked, edge-sensitive line is held as a pending bit. When power returns, software issues a flush command. The block then replays every held interrupt to the parent controller as a one-cycle pulse on that line's output, and clears what it replayed.

Configuration uses a plain register port with valid, write, address and data signals. The port accepts every access in the cycle it is presented and applies no back-pressure, so it has no ready signal. Each read returns its data one cycle later, qualified by a read-valid strobe. Mask, sensitivity and polarity are changed through separate set and clear register groups. Each line occupies one bit of a 32-bit word. A layout parameter chooses between two address maps. `NUM_IRQ` must be a multiple of 32.

Top module: `irq_edge_keeper`

## Requirements
- R1: After reset, all pending, mask, sensitivity and polarity bits are 0, the control register reads 0 and `pulse_out` is 0.
- R2: Line n is held in bit (n mod 32) of the word at byte offset 4*(n/32) from the base of each register group.
- R3: In the set group of a setting, writing 1 to a bit sets that line's bit. In the clear group, writing 1 clears it. Writing 0 leaves the bit unchanged. Reading either group of the pair returns the current setting.
- R4: With `LAYOUT`=1, the group bases are: control 0x300, status 0x000, acknowledge 0x040, mask set/clear 0x0C0/0x100, sensitivity set/clear 0x180/0x1C0, polarity set/clear 0x240/0x280.
- R5: With `LAYOUT`=2, the group bases are: acknowledge 0x080, control 0x600, status 0x000, polarity set/clear 0x480/0x500, mask set/clear 0x180/0x200, sensitivity set/clear 0x300/0x380. An address outside every group reads 0, and a write to it changes nothing.
- R6: Control bit 0 is the enable bit and control bit 1 is the edge-record bit. An edge is recorded only while both bits are 1.
- R7: Each input passes through a register before edge detection. Polarity 1 records rising edges and polarity 0 records falling edges. The pending bit becomes readable two clock edges after the input changes.
- R8: A line whose mask bit is 1, or whose sensitivity bit is 0 (level), is never recorded.
- R9: Writing 1 to a line's acknowledge bit clears its pending bit, and writing 0 has no effect. If an edge is recorded in the same cycle as the acknowledge, the new edge wins.
- R10: Writing control with bit 2 set performs a flush. On the next cycle, `pulse_out` equals the pending vector for exactly one cycle, and those pending bits are cleared. Bit 2 reads back as 0.
- R11: A read presented in cycle t returns `reg_rdata` with `reg_rvalid` high in cycle t+1. The status group returns the pending bits, and the acknowledge group reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | External interrupt lines |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| pulse_out | output | NUM_IRQ | One-cycle replay pulses to the parent controller |

## Verification
An input change reaches the pending bits two clock edges later: one edge for the input register and one for the pending update. A status read therefore starts only after two full cycles have passed since the bench drove the line. Register writes take effect on the edge that accepts them, and read data appears one edge after the request. The bench drives inputs on the falling edge and samples results on the following falling edge. The replay pulse is checked on the falling edge just after the flush write is accepted. It is checked again one cycle later to confirm that it has dropped.

// File: rtl/irq_keep_pkg.sv
package irq_keep_pkg;

  localparam int WORD_W   = 32;
  localparam int CTL_EN   = 0;
  localparam int CTL_EDGE = 1;
  localparam int CTL_FLSH = 2;

  typedef enum logic [3:0] {
    GRP_STAT, GRP_ACK, GRP_MSET, GRP_MCLR, GRP_SSET,
    GRP_SCLR, GRP_PSET, GRP_PCLR, GRP_CTRL, GRP_NONE
  } grp_e;

  function automatic logic [11:0] grp_base(input int layout, input grp_e g);
    logic [11:0] b;
    if (layout == 2) begin
      case (g)
        GRP_ACK:  b = 12'h080;
        GRP_MSET: b = 12'h180;
        GRP_MCLR: b = 12'h200;
        GRP_SSET: b = 12'h300;
        GRP_SCLR: b = 12'h380;
        GRP_PSET: b = 12'h480;
        GRP_PCLR: b = 12'h500;
        GRP_CTRL: b = 12'h600;
        default:  b = 12'h000;
      endcase
    end else begin
      case (g)
        GRP_ACK:  b = 12'h040;
        GRP_MSET: b = 12'h0C0;
        GRP_MCLR: b = 12'h100;
        GRP_SSET: b = 12'h180;
        GRP_SCLR: b = 12'h1C0;
        GRP_PSET: b = 12'h240;
        GRP_PCLR: b = 12'h280;
        GRP_CTRL: b = 12'h300;
        default:  b = 12'h000;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/irq_keep_decode.sv
module irq_keep_decode
  import irq_keep_pkg::*;
#(
  parameter int LAYOUT = 1,
  parameter int NW     = 2,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic [IDX_W-1:0]  word
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NW * 4);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(grp_base(LAYOUT, GRP_CTRL));

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;

  always_comb begin
    grp  = GRP_NONE;
    word = '0;
    base = '0;
    off  = '0;
    for (int g = 0; g < 8; g++) begin
      base = ADDR_W'(grp_base(LAYOUT, grp_e'(g)));
      off  = addr - base;
      if (addr >= base && off < SPAN && addr[1:0] == 2'b00) begin
        grp  = grp_e'(g);
        word = IDX_W'(off >> 2);
      end
    end
    if (addr == CTRL_A) begin
      grp  = GRP_CTRL;
      word = '0;
    end
  end

endmodule

// File: rtl/irq_keep_cfg.sv
module irq_keep_cfg
  import irq_keep_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NW      = 2,
  parameter int IDX_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  grp_e               grp,
  input  logic [IDX_W-1:0]   word,
  input  logic [WORD_W-1:0]  wdata,
  output logic [NUM_IRQ-1:0] mask,
  output logic [NUM_IRQ-1:0] sens,
  output logic [NUM_IRQ-1:0] pol,
  output logic               en,
  output logic               edge_mode,
  output logic               flush,
  output logic [NUM_IRQ-1:0] ack_clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      sens <= '0;
      pol  <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NW; w++) begin
        if (word == IDX_W'(w)) begin
          case (grp)
            GRP_MSET: mask[w*WORD_W +: WORD_W] <= mask[w*WORD_W +: WORD_W] | wdata;
            GRP_MCLR: mask[w*WORD_W +: WORD_W] <= mask[w*WORD_W +: WORD_W] & ~wdata;
            GRP_SSET: sens[w*WORD_W +: WORD_W] <= sens[w*WORD_W +: WORD_W] | wdata;
            GRP_SCLR: sens[w*WORD_W +: WORD_W] <= sens[w*WORD_W +: WORD_W] & ~wdata;
            GRP_PSET: pol[w*WORD_W +: WORD_W]  <= pol[w*WORD_W +: WORD_W] | wdata;
            GRP_PCLR: pol[w*WORD_W +: WORD_W]  <= pol[w*WORD_W +: WORD_W] & ~wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      edge_mode <= 1'b0;
    end else if (wr_en && grp == GRP_CTRL) begin
      en        <= wdata[CTL_EN];
      edge_mode <= wdata[CTL_EDGE];
    end
  end

  assign flush = wr_en && grp == GRP_CTRL && wdata[CTL_FLSH];

  always_comb begin
    ack_clr = '0;
    if (wr_en && grp == GRP_ACK) begin
      for (int w = 0; w < NW; w++) begin
        if (word == IDX_W'(w)) ack_clr[w*WORD_W +: WORD_W] = wdata;
      end
    end
  end

endmodule

// File: rtl/irq_keep_capture.sv
module irq_keep_capture #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] sens,
  input  logic [NUM_IRQ-1:0] pol,
  input  logic               arm,
  input  logic [NUM_IRQ-1:0] ack_clr,
  input  logic               flush,
  output logic [NUM_IRQ-1:0] pending,
  output logic [NUM_IRQ-1:0] pulse
);

  logic [NUM_IRQ-1:0] irq_s, irq_d;
  logic [NUM_IRQ-1:0] hit, rec, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_s <= '0;
      irq_d <= '0;
    end else begin
      irq_s <= irq_in;
      irq_d <= irq_s;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign hit[i] = pol[i] ? (irq_s[i] & ~irq_d[i]) : (~irq_s[i] & irq_d[i]);
    assign rec[i] = arm & hit[i] & sens[i] & ~mask[i];
  end

  assign clr = ack_clr | (flush ? pending : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      pulse   <= '0;
    end else begin
      pending <= (pending & ~clr) | rec;
      pulse   <= flush ? pending : '0;
    end
  end

endmodule

// File: rtl/irq_edge_keeper.sv
module irq_edge_keeper
  import irq_keep_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int LAYOUT  = 1,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               reg_rvalid,
  output logic [NUM_IRQ-1:0] pulse_out
);

  localparam int NW    = NUM_IRQ / WORD_W;
  localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;

  grp_e               grp;
  logic [IDX_W-1:0]   widx;
  logic [NUM_IRQ-1:0] cfg_mask, cfg_sens, cfg_pol, ack_clr, pend_q;
  logic               ctl_en, ctl_edge, flush_req, arm;
  logic               wr_en, rd_en;

  assign wr_en = reg_valid & reg_write;
  assign rd_en = reg_valid & ~reg_write;
  assign arm   = ctl_en & ctl_edge;

  irq_keep_decode #(.LAYOUT(LAYOUT), .NW(NW), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr (reg_addr),
    .grp  (grp),
    .word (widx)
  );

  irq_keep_cfg #(.NUM_IRQ(NUM_IRQ), .NW(NW), .IDX_W(IDX_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .grp       (grp),
    .word      (widx),
    .wdata     (reg_wdata),
    .mask      (cfg_mask),
    .sens      (cfg_sens),
    .pol       (cfg_pol),
    .en        (ctl_en),
    .edge_mode (ctl_edge),
    .flush     (flush_req),
    .ack_clr   (ack_clr)
  );

  irq_keep_capture #(.NUM_IRQ(NUM_IRQ)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .mask    (cfg_mask),
    .sens    (cfg_sens),
    .pol     (cfg_pol),
    .arm     (arm),
    .ack_clr (ack_clr),
    .flush   (flush_req),
    .pending (pend_q),
    .pulse   (pulse_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd_en;
      if (rd_en) begin
        case (grp)
          GRP_STAT:            reg_rdata <= pend_q[int'(widx)*WORD_W +: WORD_W];
          GRP_MSET, GRP_MCLR:  reg_rdata <= cfg_mask[int'(widx)*WORD_W +: WORD_W];
          GRP_SSET, GRP_SCLR:  reg_rdata <= cfg_sens[int'(widx)*WORD_W +: WORD_W];
          GRP_PSET, GRP_PCLR:  reg_rdata <= cfg_pol[int'(widx)*WORD_W +: WORD_W];
          GRP_CTRL:            reg_rdata <= {30'b0, ctl_edge, ctl_en};
          default:             reg_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_edge_keeper_chk.sv
module irq_edge_keeper_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_valid,
  input logic               reg_write,
  input logic               reg_rvalid,
  input logic [NUM_IRQ-1:0] pulse_out,
  input logic [NUM_IRQ-1:0] pending,
  input logic [NUM_IRQ-1:0] mask,
  input logic [NUM_IRQ-1:0] sens,
  input logic               arm,
  input logic               flush
);

  // R10
  pulse_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out & ~$past(pending)) == '0);

  // R10
  pulse_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_out) |-> $past(flush));

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pulse_out) && !flush) |=> (pulse_out == '0));

  // R6
  record_when_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~$past(pending)) != '0) |-> $past(arm));

  // R8
  no_blocked_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~$past(pending) & ($past(mask) | ~$past(sens))) == '0);

  // R11
  read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> reg_rvalid);

endmodule

bind irq_edge_keeper irq_edge_keeper_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_valid  (reg_valid),
  .reg_write  (reg_write),
  .reg_rvalid (reg_rvalid),
  .pulse_out  (pulse_out),
  .pending    (pend_q),
  .mask       (cfg_mask),
  .sens       (cfg_sens),
  .arm        (arm),
  .flush      (flush_req)
);

// File: tb/sim_irq_edge_keeper.sv
module sim_irq_edge_keeper;

  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  localparam int G_STAT = 0, G_ACK = 1, G_MSET = 2, G_MCLR = 3, G_SSET = 4;
  localparam int G_SCLR = 5, G_PSET = 6, G_PCLR = 7, G_CTRL = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         bus_v [2];
  logic         bus_w [2];
  logic [11:0]  bus_a [2];
  logic [31:0]  bus_d [2];
  logic [31:0]  bus_rd [2];
  logic         bus_rv [2];
  logic [N-1:0] bus_pl [2];

  int nvec = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_edge_keeper #(.NUM_IRQ(N), .LAYOUT(1)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_valid(bus_v[0]), .reg_write(bus_w[0]), .reg_addr(bus_a[0]), .reg_wdata(bus_d[0]),
    .reg_rdata(bus_rd[0]), .reg_rvalid(bus_rv[0]), .pulse_out(bus_pl[0])
  );

  irq_edge_keeper #(.NUM_IRQ(N), .LAYOUT(2)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_valid(bus_v[1]), .reg_write(bus_w[1]), .reg_addr(bus_a[1]), .reg_wdata(bus_d[1]),
    .reg_rdata(bus_rd[1]), .reg_rvalid(bus_rv[1]), .pulse_out(bus_pl[1])
  );

  // group bases per R4 (s=0) and R5 (s=1)
  function automatic logic [11:0] gb(input int s, input int g);
    logic [11:0] l1 [9] = '{12'h000, 12'h040, 12'h0C0, 12'h100, 12'h180, 12'h1C0, 12'h240, 12'h280, 12'h300};
    logic [11:0] l2 [9] = '{12'h000, 12'h080, 12'h180, 12'h200, 12'h300, 12'h380, 12'h480, 12'h500, 12'h600};
    return (s == 0) ? l1[g] : l2[g];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_a(input int s, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_v[s] = 1'b1; bus_w[s] = 1'b1; bus_a[s] = a; bus_d[s] = d;
    @(negedge clk);
    bus_v[s] = 1'b0; bus_w[s] = 1'b0;
  endtask

  task automatic wr(input int s, input int g, input int w, input logic [31:0] d);
    wr_a(s, gb(s, g) + 12'(4 * w), d);
  endtask

  task automatic rd_a(input int s, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_v[s] = 1'b1; bus_w[s] = 1'b0; bus_a[s] = a;
    @(negedge clk);
    d = bus_rd[s];
    if (bus_rv[s] !== 1'b1) begin
      nfail++;
      $display("FAIL R11 actual=rvalid %b expected=1", bus_rv[s]);
    end
    nvec++;
    bus_v[s] = 1'b0;
  endtask

  task automatic rd64(input int s, input int g, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd_a(s, gb(s, g), lo);
    rd_a(s, gb(s, g) + 12'd4, hi);
    v = {hi, lo};
  endtask

  task automatic drive(input logic [N-1:0] v);
    @(negedge clk);
    irq_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_layout(input int s);
    string tag;
    logic [63:0] v, exp, m_mask, m_sens, m_pol, ackv;
    logic [31:0] r;
    tag = (s == 0) ? "R4" : "R5";

    // R6: nothing recorded while disabled or with only enable set
    wr(s, G_SSET, 0, 32'hFFFFFFFF);
    wr(s, G_SSET, 1, 32'hFFFFFFFF);
    wr(s, G_PSET, 0, 32'h0000FFFF);
    wr(s, G_PSET, 1, 32'h5555AAAA);
    drive('1); drive('0);
    rd64(s, G_STAT, v); check("R6 disabled", v, 64'h0);
    wr(s, G_CTRL, 0, 32'h1);
    drive('1); drive('0);
    rd64(s, G_STAT, v); check("R6 enable-only", v, 64'h0);
    wr(s, G_CTRL, 0, 32'h3);
    rd_a(s, gb(s, G_CTRL), r); check("R6 ctrl", 64'(r), 64'h3);

    // R3 set/clear pairs with readback through both addresses
    wr(s, G_MSET, 0, 32'h000000F0);
    wr(s, G_MSET, 1, 32'h80000000);
    wr(s, G_SCLR, 0, 32'h00000F00);
    wr(s, G_SCLR, 1, 32'h00000001);
    wr(s, G_PCLR, 1, 32'h00000000);
    m_mask = 64'h80000000_000000F0;
    m_sens = 64'hFFFFFFFE_FFFFF0FF;
    m_pol  = 64'h5555AAAA_0000FFFF;
    rd64(s, G_MSET, v); check("R3 mask set view", v, m_mask);
    rd64(s, G_MCLR, v); check("R3 mask clr view", v, m_mask);
    rd64(s, G_SCLR, v); check("R3 sens", v, m_sens);
    rd64(s, G_PSET, v); check("R3 pol", v, m_pol);

    // R7 rising then falling, R8 blocked lines
    drive('1);
    exp = m_pol & m_sens & ~m_mask;
    rd64(s, G_STAT, v); check("R7 rise", v, exp);
    drive('0);
    exp = exp | (~m_pol & m_sens & ~m_mask);
    rd64(s, G_STAT, v); check("R7 fall", v, exp);
    check("R8 masked/level", v & (m_mask | ~m_sens), 64'h0);

    // R9 acknowledge
    ackv = 64'hF0000000_0000000F;
    wr(s, G_ACK, 0, ackv[31:0]);
    wr(s, G_ACK, 1, ackv[63:32]);
    wr(s, G_ACK, 0, 32'h0);
    exp = exp & ~ackv;
    rd64(s, G_STAT, v); check("R9 ack", v, exp);
    rd64(s, G_ACK, v); check("R11 ack reads 0", v, 64'h0);

    // R4/R5 decode boundaries
    wr_a(s, 12'h3F0, 32'hFFFFFFFF);
    rd_a(s, 12'h3F0, r); check({tag, " hole read"}, 64'(r), 64'h0);
    rd64(s, G_MSET, v); check({tag, " hole write"}, v, m_mask);
    wr_a(s, (s == 0) ? 12'h600 : 12'h300, 32'h0);
    rd_a(s, gb(s, G_CTRL), r); check({tag, " other ctrl addr"}, 64'(r), 64'h3);

    // R10 flush
    @(negedge clk);
    bus_v[s] = 1'b1; bus_w[s] = 1'b1; bus_a[s] = gb(s, G_CTRL); bus_d[s] = 32'h7;
    @(negedge clk);
    bus_v[s] = 1'b0; bus_w[s] = 1'b0;
    check("R10 pulse vector", bus_pl[s], exp);
    check("R10 pulse count", 64'($countones(bus_pl[s])), 64'($countones(exp)));
    @(negedge clk);
    check("R10 pulse one cycle", bus_pl[s], 64'h0);
    rd64(s, G_STAT, v); check("R10 cleared", v, 64'h0);
    rd_a(s, gb(s, G_CTRL), r); check("R10 flush bit reads 0", 64'(r), 64'h3);

    // R2 per-line sweep, rising polarity, no mask
    wr(s, G_MCLR, 0, 32'hFFFFFFFF); wr(s, G_MCLR, 1, 32'hFFFFFFFF);
    wr(s, G_SSET, 0, 32'hFFFFFFFF); wr(s, G_SSET, 1, 32'hFFFFFFFF);
    wr(s, G_PSET, 0, 32'hFFFFFFFF); wr(s, G_PSET, 1, 32'hFFFFFFFF);
    for (int n = 0; n < N; n++) begin
      drive(N'(1) << n);
      rd_a(s, gb(s, G_STAT) + 12'(4 * (n / 32)), r);
      check("R2 line bit", 64'(r), 64'(32'h1 << (n % 32)));
      wr_a(s, gb(s, G_ACK) + 12'(4 * (n / 32)), 32'h1 << (n % 32));
      drive('0);
      rd_a(s, gb(s, G_STAT) + 12'(4 * (n / 32)), r);
      check("R9 line ack", 64'(r), 64'h0);
    end
    wr(s, G_CTRL, 0, 32'h0);
  endtask

  initial begin
    logic [63:0] v;
    logic [31:0] r;
    for (int s = 0; s < 2; s++) begin
      bus_v[s] = 1'b0; bus_w[s] = 1'b0; bus_a[s] = '0; bus_d[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++) begin
      check("R1 pulse", bus_pl[s], 64'h0);
      rd64(s, G_STAT, v); check("R1 pending", v, 64'h0);
      rd64(s, G_MSET, v); check("R1 mask", v, 64'h0);
      rd64(s, G_SSET, v); check("R1 sens", v, 64'h0);
      rd64(s, G_PSET, v); check("R1 pol", v, 64'h0);
      rd_a(s, gb(s, G_CTRL), r); check("R1 ctrl", 64'(r), 64'h0);
    end
    run_layout(0);
    run_layout(1);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nvec++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule